// File: doc/BRIEF.md
# RC Time-Constant Calibration Controller

This block is the digital half of an on-chip RC time-constant calibration loop for a tunable channel filter. A reference current, set by a reference voltage across an on-chip resistor, charges a binary-weighted capacitor array for a fixed count of clock periods. A comparator then reports whether the capacitor voltage ended above the reference voltage. The controller runs a successive-approximation search over the 6-bit capacitor code, most significant bit first. For every trial code it sequences the discharge, charge-current, sample and compare controls through one fixed 16-cycle step. Six steps resolve the code in 96 cycles, which is 7.68 µs at 12.5 MHz.

Calibration always runs in one reference setting: zero-IF mode with the 4 MHz resistor word. Between runs the block holds a configuration register with a filter mode (zero-IF or low-IF) and a 2-bit bandwidth select. From that register it drives a thermometer-coded resistor-array word and a capacitor-halving control. With these, the single calibrated code serves all eight cut-off settings.

Top module: `rc_cal_ctrl`

## Requirements
- R1: After reset, busy, done, every switch control and the compare enable are low, the capacitor code is 000000, the resistor word is 0000 and the halving control is low.
- R2: A start pulse while idle makes busy high from the next cycle, with trial code 100000 presented in that first cycle.
- R3: A calibration keeps busy high for exactly 96 cycles, made of six steps of 16 cycles each.
- R4: Within a step (cycle 0 to 15), discharge is high in cycles 0, 1 and 15. Sample is high only in cycle 13, and compare enable only in cycle 14.
- R5: Charge-current enable is high in cycles 0 to 12. Discharge never falls while the current is off, and discharge and current enable never fall in the same cycle.
- R6: At the end of cycle 14 of the step for bit b, bit b becomes the comparator value (1 = capacitor voltage above reference, keep). Bit b-1 is then set to 1 as the next trial. The final code is the largest code that the comparator accepts.
- R7: Done is high for exactly one cycle, in the cycle after the last busy cycle, with busy low. The final code then holds until the next start or reset.
- R8: A start pulse while busy is ignored: the run length and the resolved code are unchanged.
- R9: While busy, the resistor word is 1110 and the halving control is 0, whatever the configuration holds.
- R10: While idle, the resistor word follows the held bandwidth select: 00 gives 0000, 01 gives 1000, 10 gives 1100 and 11 gives 1110 (word shown bit 3 down to bit 0).
- R11: While idle, the halving control equals the held mode bit (1 = low-IF).
- R12: The mode and bandwidth inputs are captured only in a cycle where the configuration write strobe is high. Changes to them at other times have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request, sampled while idle |
| cmp_hi_i | input | 1 | Comparator: capacitor voltage above reference |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_lowif_i | input | 1 | Mode to store, 1 = low-IF |
| cfg_bw_i | input | 2 | Bandwidth select to store |
| cap_code_o | output | 6 | Trial code while busy, final code afterwards |
| cap_half_o | output | 1 | Capacitor-halving control |
| res_word_o | output | 4 | Thermometer resistor-array word |
| sw_dis_o | output | 1 | Discharge switch control |
| sw_chg_o | output | 1 | Charge-current enable |
| sw_smp_o | output | 1 | Sample switch control |
| cmp_en_o | output | 1 | Comparator evaluation enable |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of functions can meet in the same cycle. A start request can arrive while a search is still counting. A configuration write can land during a run, when the outputs must keep the reference setting. The bench raises start in the middle of a run and writes a new mode and bandwidth while busy. A behavioural model, advanced on every clock, judges that the run length, the code bits and the forced resistor word are unaffected, and that the new setting appears only once busy has fallen. Comparator targets of 0, 63 and two mid-range values push the search to both ends of the code range.

// File: rtl/rc_cal_pkg.sv
package rc_cal_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DIS,
    PH_CHG,
    PH_SMP,
    PH_CMP,
    PH_RST
  } phase_e;

endpackage

// File: rtl/rc_cal_timer.sv
module rc_cal_timer #(
  parameter int CODE_W   = 6,
  parameter int STEP_CYC = 16,
  parameter int CMP_AT   = 14
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [$clog2(STEP_CYC)-1:0] cyc_o,
  output logic [$clog2(CODE_W)-1:0]   step_o,
  output logic                        launch_o,
  output logic                        decide_o
);
  localparam int CNT_W  = $clog2(STEP_CYC);
  localparam int STEP_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0]  CYC_LAST  = CNT_W'(STEP_CYC - 1);
  localparam logic [CNT_W-1:0]  CYC_CMP   = CNT_W'(CMP_AT);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(CODE_W - 1);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  cyc_q, cyc_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              launch, cnt_en;

  assign launch = start_i & ~busy_q;
  assign cnt_en = launch | busy_q;

  always_comb begin
    busy_d = busy_q;
    cyc_d  = cyc_q;
    step_d = step_q;
    done_d = 1'b0;
    if (launch) begin
      busy_d = 1'b1;
      cyc_d  = '0;
      step_d = '0;
    end else if (busy_q) begin
      if (cyc_q == CYC_LAST) begin
        cyc_d = '0;
        if (step_q == STEP_LAST) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
      step_q <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cyc_q  <= cyc_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign cyc_o    = cyc_q;
  assign step_o   = step_q;
  assign launch_o = launch;
  assign decide_o = busy_q & (cyc_q == CYC_CMP);
endmodule

// File: rtl/rc_cal_sar.sv
module rc_cal_sar #(
  parameter int CODE_W = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      launch_i,
  input  logic                      decide_i,
  input  logic [$clog2(CODE_W)-1:0] step_i,
  input  logic                      cmp_hi_i,
  output logic [CODE_W-1:0]         code_o
);
  localparam logic [CODE_W-1:0] FIRST_TRIAL = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;
  int                bidx;

  assign code_en = launch_i | decide_i;

  always_comb begin
    code_d = code_q;
    bidx   = CODE_W - 1 - int'(step_i);
    if (launch_i) begin
      code_d = FIRST_TRIAL;
    end else if (decide_i) begin
      for (int i = 0; i < CODE_W; i++) begin
        if (i == bidx)     code_d[i] = cmp_hi_i;
        if (i == bidx - 1) code_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/rc_cal_phase.sv
module rc_cal_phase
  import rc_cal_pkg::*;
#(
  parameter int STEP_CYC = 16,
  parameter int DIS_CYC  = 2,
  parameter int CHG_CYC  = 11
) (
  input  logic                        busy_i,
  input  logic [$clog2(STEP_CYC)-1:0] cyc_i,
  output logic                        sw_dis_o,
  output logic                        sw_chg_o,
  output logic                        sw_smp_o,
  output logic                        cmp_en_o
);
  localparam int CNT_W = $clog2(STEP_CYC);
  localparam logic [CNT_W-1:0] CHG_FROM = CNT_W'(DIS_CYC);
  localparam logic [CNT_W-1:0] SMP_AT   = CNT_W'(DIS_CYC + CHG_CYC);
  localparam logic [CNT_W-1:0] CMP_AT   = CNT_W'(DIS_CYC + CHG_CYC + 1);

  phase_e phase;

  always_comb begin
    if (!busy_i)               phase = PH_IDLE;
    else if (cyc_i < CHG_FROM) phase = PH_DIS;
    else if (cyc_i < SMP_AT)   phase = PH_CHG;
    else if (cyc_i == SMP_AT)  phase = PH_SMP;
    else if (cyc_i == CMP_AT)  phase = PH_CMP;
    else                       phase = PH_RST;
  end

  assign sw_dis_o = (phase == PH_DIS) || (phase == PH_RST);
  assign sw_chg_o = (phase == PH_DIS) || (phase == PH_CHG);
  assign sw_smp_o = (phase == PH_SMP);
  assign cmp_en_o = (phase == PH_CMP);
endmodule

// File: rtl/rc_cal_rsel.sv
module rc_cal_rsel #(
  parameter int RES_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic                     cfg_lowif_i,
  input  logic [$clog2(RES_W)-1:0] cfg_bw_i,
  input  logic                     busy_i,
  output logic [RES_W-1:0]         res_word_o,
  output logic                     cap_half_o
);
  localparam int BW_W = $clog2(RES_W);
  localparam logic [BW_W-1:0] REF_SEL = BW_W'(RES_W - 1);

  logic            lowif_q;
  logic [BW_W-1:0] bw_q;
  logic [BW_W-1:0] sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lowif_q <= 1'b0;
      bw_q    <= '0;
    end else if (cfg_we_i) begin
      lowif_q <= cfg_lowif_i;
      bw_q    <= cfg_bw_i;
    end
  end

  assign sel = busy_i ? REF_SEL : bw_q;

  for (genvar j = 0; j < RES_W; j++) begin : g_therm
    assign res_word_o[j] = (int'(sel) >= (RES_W - j));
  end

  assign cap_half_o = lowif_q & ~busy_i;
endmodule

// File: rtl/rc_cal_ctrl.sv
module rc_cal_ctrl #(
  parameter int CODE_W   = 6,
  parameter int STEP_CYC = 16,
  parameter int DIS_CYC  = 2,
  parameter int CHG_CYC  = 11,
  parameter int RES_W    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     cmp_hi_i,
  input  logic                     cfg_we_i,
  input  logic                     cfg_lowif_i,
  input  logic [$clog2(RES_W)-1:0] cfg_bw_i,
  output logic [CODE_W-1:0]        cap_code_o,
  output logic                     cap_half_o,
  output logic [RES_W-1:0]         res_word_o,
  output logic                     sw_dis_o,
  output logic                     sw_chg_o,
  output logic                     sw_smp_o,
  output logic                     cmp_en_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam int CNT_W  = $clog2(STEP_CYC);
  localparam int STEP_W = $clog2(CODE_W);
  localparam int CMP_AT = DIS_CYC + CHG_CYC + 1;

  logic              rst_meta_q, rst_sync_q;
  logic [CNT_W-1:0]  cyc;
  logic [STEP_W-1:0] step;
  logic              launch, decide, busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rc_cal_timer #(
    .CODE_W  (CODE_W),
    .STEP_CYC(STEP_CYC),
    .CMP_AT  (CMP_AT)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .start_i (start_i),
    .busy_o  (busy),
    .done_o  (done_o),
    .cyc_o   (cyc),
    .step_o  (step),
    .launch_o(launch),
    .decide_o(decide)
  );

  rc_cal_sar #(
    .CODE_W(CODE_W)
  ) u_sar (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .launch_i(launch),
    .decide_i(decide),
    .step_i  (step),
    .cmp_hi_i(cmp_hi_i),
    .code_o  (cap_code_o)
  );

  rc_cal_phase #(
    .STEP_CYC(STEP_CYC),
    .DIS_CYC (DIS_CYC),
    .CHG_CYC (CHG_CYC)
  ) u_phase (
    .busy_i  (busy),
    .cyc_i   (cyc),
    .sw_dis_o(sw_dis_o),
    .sw_chg_o(sw_chg_o),
    .sw_smp_o(sw_smp_o),
    .cmp_en_o(cmp_en_o)
  );

  rc_cal_rsel #(
    .RES_W(RES_W)
  ) u_rsel (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .cfg_we_i   (cfg_we_i),
    .cfg_lowif_i(cfg_lowif_i),
    .cfg_bw_i   (cfg_bw_i),
    .busy_i     (busy),
    .res_word_o (res_word_o),
    .cap_half_o (cap_half_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/rc_cal_ctrl_chk.sv
module rc_cal_ctrl_chk #(
  parameter int CODE_W   = 6,
  parameter int STEP_CYC = 16,
  parameter int RES_W    = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic [CODE_W-1:0]        cap_code_o,
  input logic                     cap_half_o,
  input logic [RES_W-1:0]         res_word_o,
  input logic                     sw_dis_o,
  input logic                     sw_chg_o,
  input logic                     sw_smp_o,
  input logic                     cmp_en_o,
  input logic                     busy_o,
  input logic                     done_o
);
  localparam int RUN_CYC = CODE_W * STEP_CYC;
  localparam logic [RES_W-1:0] REF_WORD = {RES_W{1'b1}} << 1;

  int run_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt_q <= 0;
    else if (busy_o) run_cnt_q <= run_cnt_q + 1;
    else             run_cnt_q <= 0;
  end

  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_cnt_q == RUN_CYC); // R3

  AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sw_smp_o, cmp_en_o, sw_chg_o & ~sw_dis_o})); // R4

  AST_CURRENT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sw_dis_o) && busy_o) |-> sw_chg_o); // R5

  AST_NO_JOINT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($fell(sw_dis_o) && $fell(sw_chg_o))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R7

  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(cap_code_o)); // R7

  AST_REF_SETTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (res_word_o == REF_WORD && !cap_half_o)); // R9
endmodule

bind rc_cal_ctrl rc_cal_ctrl_chk #(
  .CODE_W  (CODE_W),
  .STEP_CYC(STEP_CYC),
  .RES_W   (RES_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .cap_code_o(cap_code_o),
  .cap_half_o(cap_half_o),
  .res_word_o(res_word_o),
  .sw_dis_o  (sw_dis_o),
  .sw_chg_o  (sw_chg_o),
  .sw_smp_o  (sw_smp_o),
  .cmp_en_o  (cmp_en_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/rc_cal_ctrl_test.sv
module rc_cal_ctrl_test;
  localparam int CLK_PERIOD = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cmp_hi = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_lowif = 1'b0;
  logic [1:0] cfg_bw = 2'd0;
  logic [5:0] cap_code;
  logic       cap_half;
  logic [3:0] res_word;
  logic       sw_dis, sw_chg, sw_smp, cmp_en, busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  int target  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int m_busy, m_cyc, m_step, m_code, m_done, m_mode, m_bw;

  rc_cal_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_hi_i(cmp_hi),
    .cfg_we_i(cfg_we), .cfg_lowif_i(cfg_lowif), .cfg_bw_i(cfg_bw),
    .cap_code_o(cap_code), .cap_half_o(cap_half), .res_word_o(res_word),
    .sw_dis_o(sw_dis), .sw_chg_o(sw_chg), .sw_smp_o(sw_smp),
    .cmp_en_o(cmp_en), .busy_o(busy), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int therm(input int sel);
    int w = 0;
    for (int j = 0; j < 4; j++) if (sel >= 4 - j) w |= (1 << j);
    return w;
  endfunction

  // comparator model: voltage above reference while trial code is not above target
  always @(negedge clk) cmp_hi = (int'(cap_code) <= target);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cyc = 0; m_step = 0; m_code = 0; m_done = 0; m_mode = 0; m_bw = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        if (m_cyc == 14) begin
          int b;
          b = 5 - m_step;
          if (cmp_hi) m_code = m_code | (1 << b);
          else        m_code = m_code & ~(1 << b);
          if (b > 0) m_code = m_code | (1 << (b - 1));
        end
        if (m_cyc == 15) begin
          m_cyc = 0;
          if (m_step == 5) begin m_busy = 0; m_done = 1; end
          else m_step = m_step + 1;
        end else m_cyc = m_cyc + 1;
      end else if (start) begin
        m_busy = 1; m_cyc = 0; m_step = 0; m_code = 32;
      end
      if (cfg_we) begin m_mode = int'(cfg_lowif); m_bw = int'(cfg_bw); end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3", "busy", int'(busy), m_busy);
      chk("R7", "done", int'(done), m_done);
      chk("R6", "cap_code", int'(cap_code), m_code);
      chk("R4", "sw_dis", int'(sw_dis), int'(m_busy != 0 && (m_cyc < 2 || m_cyc == 15)));
      chk("R5", "sw_chg", int'(sw_chg), int'(m_busy != 0 && m_cyc < 13));
      chk("R4", "sw_smp", int'(sw_smp), int'(m_busy != 0 && m_cyc == 13));
      chk("R4", "cmp_en", int'(cmp_en), int'(m_busy != 0 && m_cyc == 14));
      if (m_busy != 0) begin
        chk("R9", "res_word", int'(res_word), 4'b1110);
        chk("R9", "cap_half", int'(cap_half), 0);
      end else begin
        chk("R10", "res_word", int'(res_word), therm(m_bw));
        chk("R11", "cap_half", int'(cap_half), m_mode);
      end
    end
  end

  task automatic cfg_write(input int mode, input int bw);
    cfg_lowif = mode[0]; cfg_bw = bw[1:0]; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cal(input int tgt, input bit poke);
    int n;
    target = tgt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    chk("R2", "first trial", int'(cap_code), 32);
    n = 0;
    while (busy && n < 200) begin
      n++;
      if (poke && n == 40) start = 1'b1;                 // R8 start while busy
      if (poke && n == 50) begin cfg_lowif = 1'b1; cfg_bw = 2'd2; cfg_we = 1'b1; end
      @(negedge clk);
      start = 1'b0; cfg_we = 1'b0;
      if (poke && n == 50) chk("R9", "word after busy write", int'(res_word), 4'b1110);
    end
    chk("R3", "busy cycles", n, 96);
    chk("R7", "done at end", int'(done), 1);
    chk("R6", "final code", int'(cap_code), tgt);
    if (poke) chk("R8", "code despite restart", int'(cap_code), tgt);
    @(negedge clk);
    chk("R7", "done drops", int'(done), 0);
    chk("R7", "code held", int'(cap_code), tgt);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, observed while reset is held
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "code", int'(cap_code), 0);
    chk("R1", "switches", int'({sw_dis, sw_chg, sw_smp, cmp_en}), 0);
    chk("R1", "res_word", int'(res_word), 0);
    chk("R1", "cap_half", int'(cap_half), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 bandwidth map in zero-IF mode
    for (int bw = 0; bw < 4; bw++) begin
      cfg_write(0, bw);
      chk("R10", "word for select", int'(res_word), therm(bw));
    end
    // R11 low-IF halving
    cfg_write(1, 1);
    chk("R11", "half in low-IF", int'(cap_half), 1);
    chk("R10", "word low-IF sel 1", int'(res_word), 4'b1000);
    // R12 inputs without strobe ignored
    cfg_lowif = 1'b0; cfg_bw = 2'd3;
    repeat (2) @(negedge clk);
    chk("R12", "half unchanged", int'(cap_half), 1);
    chk("R12", "word unchanged", int'(res_word), 4'b1000);

    run_cal(37, 1'b0);
    chk("R11", "half restored after run", int'(cap_half), 1);
    run_cal(0, 1'b0);
    run_cal(63, 1'b1);
    chk("R11", "busy write applied after run", int'(cap_half), 1);
    chk("R10", "busy write word after run", int'(res_word), 4'b1100);
    cfg_write(0, 3);
    run_cal(21, 1'b1);
    repeat (5) @(negedge clk);
    chk("R7", "code held while idle", int'(cap_code), 21);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule